// File: doc/BRIEF.md
# DRAM Strobe Command Decoder

This block is the device-side control of an 18-bit multiplexed-address DRAM, built as a synthesizable behavioural target for testing memory controllers. A fast clock samples the active-low strobes: a row strobe, an upper-byte and a lower-byte column strobe, a write enable and an output enable. The block works out what kind of access is running from the order in which those strobes fall. The kinds are idle, row-only refresh, column-before-row refresh, read, early write and delayed write. It drives a per-byte output-enable and data word, and it writes individual bytes into a small internal array.

The row address is taken when the row strobe falls. The column address is taken when the first of the two column strobes falls. The array depth is a parameter. Both 9-bit addresses are XOR-folded into the array index, so a reduced array still responds to the full row and column. A flag reports an access in which the two byte lanes run in different modes.

Top module: `dram_strobe_decoder`

## Requirements
- R1: With the row strobe and both column strobes high, the block is idle: `op` reads 0 and neither `drv_lo` nor `drv_hi` is set.
- R2: If a column strobe was already low when the row strobe falls, `op` reads 2, `rfsh_ctr` advances by one, and no lane drives.
- R3: With the row strobe low and both column strobes high, `op` reads 1, no lane drives, and `rfsh_ctr` keeps its value.
- R4: When a lane's column strobe falls with write enable high, `op` reads 3. While output enable is low, that lane drives its stored byte on `dout`. The lower lane is `lcas_n` with bits 8:0, and the upper lane is `ucas_n` with bits 17:9. A lane whose strobe is high does not drive.
- R5: If write enable is low when a lane's column strobe falls, `op` reads 4. The byte on `din` in that sample is stored, and the lane never drives.
- R6: If write enable falls while a reading lane's column strobe is low, `op` reads 5. The byte on `din` in that sample is stored, and no lane drives in that access.
- R7: Both column strobes falling together write, or read, all 18 bits as one word.
- R8: The column address is taken on the earlier falling column strobe. A lane that falls later uses that same column, even if the address pins have changed.
- R9: `mix_err` is set while the two lanes are active in different modes within one row-low period. It clears once both column strobes are high.
- R10: A read access with output enable high stores nothing and drives nothing.
- R11: After reset, `op` is 0, `rfsh_ctr` is 0, `mix_err` is 0 and no lane drives.
- R12: The array index is the XOR-fold of the row into its upper half and of the column into its lower half. Different rows with the same column therefore hold separate data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, zero on lanes not driving |
| drv_lo | output | 1 | Lower byte drives the bus |
| drv_hi | output | 1 | Upper byte drives the bus |
| op | output | 3 | Access kind: 0 idle, 1 row-only, 2 column-before-row, 3 read, 4 early write, 5 delayed write |
| rfsh_ctr | output | 9 | Internal refresh counter |
| mix_err | output | 1 | Lanes in conflicting modes |

## Verification
The lower lane can store a byte at its column edge in the same row period in which the upper lane begins driving read data. This is the one place where writing and driving overlap. The bench provokes it by dropping the lower strobe with write enable low, then raising write enable and dropping the upper strobe in the next sample. It then judges three things: the upper lane's driven byte, compared against the scoreboard, must be the data held before the write; `mix_err` must be raised; and a later word read must show the newly written lower byte. Staggered lanes are also checked, to confirm that the second lane reuses the first column.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_RONLY = 3'd1,
    OP_CBR   = 3'd2,
    OP_READ  = 3'd3,
    OP_EWR   = 3'd4,
    OP_DWR   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    LM_IDLE = 2'd0,
    LM_RD   = 2'd1,
    LM_EWR  = 2'd2,
    LM_DWR  = 2'd3
  } lane_e;

  localparam int NLANES = 2;
endpackage

// File: rtl/dsd_sampler.sv
module dsd_sampler (
  input  logic clk,
  input  logic arst_n,
  input  logic ras_n,
  input  logic ucas_n,
  input  logic lcas_n,
  input  logic we_n,
  output logic rst_s,
  output logic ras_q,
  output logic ucas_q,
  output logic lcas_q,
  output logic we_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};
  assign rst_s  = sync_q[1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ras_q  <= 1'b1;
      ucas_q <= 1'b1;
      lcas_q <= 1'b1;
      we_q   <= 1'b1;
    end else begin
      ras_q  <= ras_n;
      ucas_q <= ucas_n;
      lcas_q <= lcas_n;
      we_q   <= we_n;
    end
  end
endmodule

// File: rtl/dsd_lane.sv
module dsd_lane
  import dsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ras_act,
  input  logic  clr,
  input  logic  cas_n,
  input  logic  cas_q,
  input  logic  we_n,
  input  logic  oe_n,
  input  logic  we_fall,
  output logic  start,
  output logic  wr,
  output lane_e mode_d,
  output logic  drive_d,
  output logic  drive_q
);
  lane_e mode_q;

  always_comb begin
    start  = ras_act & ~cas_n & cas_q;
    mode_d = mode_q;
    wr     = 1'b0;
    if (clr) begin
      mode_d = LM_IDLE;
    end else if (start) begin
      mode_d = we_n ? LM_RD : LM_EWR;
      wr     = ~we_n;
    end else if (we_fall && !cas_n && mode_q == LM_RD) begin
      mode_d = LM_DWR;
      wr     = 1'b1;
    end
    drive_d = ras_act & ~cas_n & (mode_d == LM_RD) & we_n & ~oe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LM_IDLE;
      drive_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      drive_q <= drive_d;
    end
  end

  // R4: a lane drives only after a low strobe, high write enable, low output enable
  p_drive_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> $past(!cas_n && we_n && !oe_n));

  // R5: an early-write lane never drives while it keeps that mode
  p_ewr_lane_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LM_EWR) |-> !drive_q);
endmodule

// File: rtl/dsd_store.sv
module dsd_store #(
  parameter int WORDS  = 256,
  parameter int BYTE_W = 9,
  parameter int NL     = 2,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int DATA_W = NL * BYTE_W
) (
  input  logic              clk,
  input  logic [NL-1:0]     wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < NL; g++) begin : g_bank
    logic [BYTE_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr[g]) mem[idx] <= wdata[g*BYTE_W +: BYTE_W];
    end
    assign rdata[g*BYTE_W +: BYTE_W] = mem[idx];
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 9,
  parameter int WORDS  = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                ucas_n,
  input  logic                lcas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*BYTE_W-1:0] din,
  output logic [2*BYTE_W-1:0] dout,
  output logic                drv_lo,
  output logic                drv_hi,
  output logic [2:0]          op,
  output logic [ADDR_W-1:0]   rfsh_ctr,
  output logic                mix_err
);
  localparam int DATA_W = NLANES * BYTE_W;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int ROW_B  = IDX_W / 2;
  localparam int COL_B  = IDX_W - ROW_B;

  function automatic logic [ROW_B-1:0] fold_row(input logic [ADDR_W-1:0] v);
    logic [ROW_B-1:0] f;
    f = '0;
    for (int i = 0; i < ADDR_W; i++) f[i % ROW_B] = f[i % ROW_B] ^ v[i];
    return f;
  endfunction

  function automatic logic [COL_B-1:0] fold_col(input logic [ADDR_W-1:0] v);
    logic [COL_B-1:0] f;
    f = '0;
    for (int i = 0; i < ADDR_W; i++) f[i % COL_B] = f[i % COL_B] ^ v[i];
    return f;
  endfunction

  logic rst_s, ras_q, ucas_q, lcas_q, we_q;

  dsd_sampler u_smp (
    .clk    (clk),
    .arst_n (rst_n),
    .ras_n  (ras_n),
    .ucas_n (ucas_n),
    .lcas_n (lcas_n),
    .we_n   (we_n),
    .rst_s  (rst_s),
    .ras_q  (ras_q),
    .ucas_q (ucas_q),
    .lcas_q (lcas_q),
    .we_q   (we_q)
  );

  logic ras_fall, we_fall, cbr_d, ras_act, both_hi, clr, first_col, rf_en;
  logic [NLANES-1:0] cas_v, cas_qv, lane_start, lane_wr, lane_drv_d, lane_drv_q;
  lane_e lane_mode [NLANES];
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d, rf_q;
  op_e  op_q, op_d;
  logic mix_q, mix_d;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rdata, dout_d, dout_q;

  assign cas_v  = {ucas_n, lcas_n};
  assign cas_qv = {ucas_q, lcas_q};

  // strobe order decode
  always_comb begin
    ras_fall  = ras_q & ~ras_n;
    we_fall   = we_q & ~we_n;
    cbr_d     = ~ras_n & (ras_fall ? (~ucas_q | ~lcas_q) : (op_q == OP_CBR));
    ras_act   = ~ras_n & ~cbr_d;
    both_hi   = ucas_n & lcas_n;
    clr       = ~ras_act | both_hi;
    first_col = ras_act & ~both_hi & ucas_q & lcas_q;
    row_d     = ras_fall ? addr : row_q;
    col_d     = first_col ? addr : col_q;
    rf_en     = ras_fall & cbr_d;
    idx       = {fold_row(row_d), fold_col(col_d)};
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    dsd_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_s),
      .ras_act (ras_act),
      .clr     (clr),
      .cas_n   (cas_v[g]),
      .cas_q   (cas_qv[g]),
      .we_n    (we_n),
      .oe_n    (oe_n),
      .we_fall (we_fall),
      .start   (lane_start[g]),
      .wr      (lane_wr[g]),
      .mode_d  (lane_mode[g]),
      .drive_d (lane_drv_d[g]),
      .drive_q (lane_drv_q[g])
    );
    assign dout_d[g*BYTE_W +: BYTE_W] =
      lane_drv_d[g] ? rdata[g*BYTE_W +: BYTE_W] : '0;
  end

  dsd_store #(.WORDS(WORDS), .BYTE_W(BYTE_W), .NL(NLANES)) u_store (
    .clk   (clk),
    .wr    (lane_wr),
    .idx   (idx),
    .wdata (din),
    .rdata (rdata)
  );

  // access kind next state
  always_comb begin
    op_d = op_q;
    if (ras_n) begin
      op_d = OP_IDLE;
    end else if (cbr_d) begin
      op_d = OP_CBR;
    end else begin
      if (ras_fall) op_d = OP_RONLY;
      if (|lane_start) op_d = we_n ? OP_READ : OP_EWR;
      if (we_fall && (lane_mode[0] == LM_DWR || lane_mode[1] == LM_DWR)) op_d = OP_DWR;
    end
    mix_d = (lane_mode[0] != LM_IDLE) && (lane_mode[1] != LM_IDLE) &&
            (lane_mode[0] != lane_mode[1]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      op_q   <= OP_IDLE;
      mix_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      rf_q   <= '0;
      dout_q <= '0;
    end else begin
      op_q   <= op_d;
      mix_q  <= mix_d;
      row_q  <= row_d;
      col_q  <= col_d;
      dout_q <= dout_d;
      if (rf_en) rf_q <= rf_q + 1'b1;
    end
  end

  assign dout     = dout_q;
  assign drv_lo   = lane_drv_q[0];
  assign drv_hi   = lane_drv_q[1];
  assign op       = op_q;
  assign rfsh_ctr = rf_q;
  assign mix_err  = mix_q;

  p_standby_off_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (ras_n && ucas_n && lcas_n) |=> (!drv_lo && !drv_hi && op_q == OP_IDLE));

  p_refresh_step_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (rf_q != $past(rf_q)) |-> (op_q == OP_CBR && !drv_lo && !drv_hi));

  p_row_only_quiet_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (op_q == OP_RONLY) |-> (!drv_lo && !drv_hi));

  p_early_quiet_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (op_q == OP_EWR && !mix_q) |-> (!drv_lo && !drv_hi));

  p_delayed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(op_q == OP_DWR) |-> (!drv_lo && !drv_hi));

  p_mix_in_row_r9: assert property (@(posedge clk) disable iff (!rst_s)
    mix_q |-> $past(!ras_n));
endmodule

// File: tb/dram_strobe_decoder_test.sv
`timescale 1ns/1ps
module dram_strobe_decoder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ras_n, ucas_n, lcas_n, we_n, oe_n;
  logic [8:0]  addr;
  logic [17:0] din, dout;
  logic drv_lo, drv_hi, mix_err;
  logic [2:0] op;
  logic [8:0] rfsh_ctr;

  dram_strobe_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .op(op), .rfsh_ctr(rfsh_ctr), .mix_err(mix_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed { logic [1:0] m; logic [17:0] d; } item_t;
  item_t exp_q[$];
  logic [17:0] model [int];

  function automatic int key(int r, int c);
    return r * 512 + c;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compare each newly driving lane against queued data
  logic [1:0] prev_drv = 2'b00;
  logic [1:0] cur_drv, new_drv;
  logic [17:0] msk;
  item_t it;
  always @(negedge clk) begin
    cur_drv = {drv_hi, drv_lo};
    new_drv = cur_drv & ~prev_drv;
    prev_drv = cur_drv;
    if (new_drv != 2'b00 && !finished) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected drive act=%0h exp=0", new_drv);
      end else begin
        it = exp_q.pop_front();
        msk = {{9{new_drv[1]}}, {9{new_drv[0]}}};
        if (it.m != new_drv || (dout & msk) != (it.d & msk)) begin
          bad++;
          $display("FAIL R4 read data lanes=%0h act=%0h exp=%0h lanes_exp=%0h",
                   new_drv, dout & msk, it.d & msk, it.m);
        end
      end
    end
  end

  task automatic idle_();
    ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 1;
    tick();
  endtask

  task automatic open_row(int r);
    addr = 9'(r); ras_n = 0;
    tick();
  endtask

  task automatic put(int r, int c, logic [1:0] m, logic [17:0] d);
    logic [17:0] old;
    old = model.exists(key(r, c)) ? model[key(r, c)] : 18'h0;
    if (m[0]) old[8:0]  = d[8:0];
    if (m[1]) old[17:9] = d[17:9];
    model[key(r, c)] = old;
  endtask

  task automatic wr_early(int r, int c, logic [1:0] m, logic [17:0] d);
    open_row(r);
    addr = 9'(c); din = d; we_n = 0; lcas_n = ~m[0]; ucas_n = ~m[1];
    tick();
    chk(op == 3'd4, "R5", "early write op", op, 4);
    chk({drv_hi, drv_lo} == 2'b00, "R5", "early write drive", {drv_hi, drv_lo}, 0);
    put(r, c, m, d);
    din = ~d;
    tick();
    idle_();
  endtask

  task automatic wr_delayed(int r, int c, logic [1:0] m, logic [17:0] d);
    open_row(r);
    addr = 9'(c); we_n = 1; oe_n = 1; lcas_n = ~m[0]; ucas_n = ~m[1];
    tick();
    din = d; we_n = 0;
    tick();
    chk(op == 3'd5, "R6", "delayed write op", op, 5);
    chk({drv_hi, drv_lo} == 2'b00, "R6", "delayed write drive", {drv_hi, drv_lo}, 0);
    put(r, c, m, d);
    din = ~d;
    tick();
    idle_();
  endtask

  task automatic rd(int r, int c, logic [1:0] m, string req);
    open_row(r);
    addr = 9'(c); we_n = 1; oe_n = 0;
    exp_q.push_back({m, model[key(r, c)]});
    lcas_n = ~m[0]; ucas_n = ~m[1];
    tick();
    tick();
    chk(op == 3'd3, req, "read op", op, 3);
    chk({drv_hi, drv_lo} == m, req, "read lanes", {drv_hi, drv_lo}, m);
    idle_();
    chk(op == 3'd0 && {drv_hi, drv_lo} == 2'b00, "R1", "idle after read", {op, drv_hi, drv_lo}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [8:0] rc;
    rst_n = 0; ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 1;
    addr = '0; din = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R11 reset state
    chk(op == 3'd0, "R11", "reset op", op, 0);
    chk(rfsh_ctr == 9'd0, "R11", "reset counter", rfsh_ctr, 0);
    chk(mix_err == 1'b0 && {drv_hi, drv_lo} == 2'b00, "R11", "reset flags", {mix_err, drv_hi, drv_lo}, 0);

    // R1 idle
    idle_();
    chk(op == 3'd0 && {drv_hi, drv_lo} == 2'b00, "R1", "standby", {op, drv_hi, drv_lo}, 0);

    // R5 / R7 word early write then word read
    wr_early(1, 2, 2'b11, 18'h2A5C3);
    rd(1, 2, 2'b11, "R7");

    // R12 same column, different row
    wr_early(2, 2, 2'b11, 18'h15A3C);
    rd(1, 2, 2'b11, "R12");
    rd(2, 2, 2'b11, "R12");

    // R5 byte write keeps the other byte
    wr_early(3, 5, 2'b11, 18'h3F00F);
    wr_early(3, 5, 2'b01, 18'h000AA);
    rd(3, 5, 2'b11, "R5");

    // R4 single lane read
    rd(3, 5, 2'b10, "R4");
    rd(3, 5, 2'b01, "R4");

    // R6 delayed write of upper byte
    wr_delayed(3, 5, 2'b10, 18'h2B400);
    rd(3, 5, 2'b11, "R6");
    wr_delayed(6, 4, 2'b11, 18'h1E1E1);
    rd(6, 4, 2'b11, "R6");

    // R3 row-only refresh
    rc = rfsh_ctr;
    open_row(7);
    tick();
    chk(op == 3'd1, "R3", "row-only op", op, 1);
    chk({drv_hi, drv_lo} == 2'b00 && rfsh_ctr == rc, "R3", "row-only quiet", {drv_hi, drv_lo, rfsh_ctr}, {2'b00, rc});
    idle_();

    // R2 column-before-row refresh, twice
    for (int k = 1; k <= 2; k++) begin
      lcas_n = 0; ucas_n = 0;
      tick();
      ras_n = 0;
      tick();
      chk(op == 3'd2, "R2", "refresh op", op, 2);
      chk(rfsh_ctr == 9'(k), "R2", "refresh counter", rfsh_ctr, k);
      chk({drv_hi, drv_lo} == 2'b00, "R2", "refresh drive", {drv_hi, drv_lo}, 0);
      ras_n = 1;
      tick();
      idle_();
    end

    // R10 output enable high
    open_row(1);
    addr = 9'd2; we_n = 1; oe_n = 1; lcas_n = 0; ucas_n = 0;
    tick(); tick();
    chk(op == 3'd3, "R10", "read op with output off", op, 3);
    chk({drv_hi, drv_lo} == 2'b00, "R10", "no drive", {drv_hi, drv_lo}, 0);
    idle_();
    rd(1, 2, 2'b11, "R10");

    // R8 staggered lanes reuse the first column
    wr_early(4, 3, 2'b11, 18'h12345);
    wr_early(4, 9, 2'b11, 18'h2FEDC);
    open_row(4);
    addr = 9'd3; we_n = 1; oe_n = 0; lcas_n = 0;
    exp_q.push_back({2'b01, model[key(4, 3)]});
    tick();
    addr = 9'd9; ucas_n = 0;
    exp_q.push_back({2'b10, model[key(4, 3)]});
    tick();
    tick();
    chk(dout[17:9] == model[key(4, 3)][17:9], "R8", "late lane column", dout[17:9], model[key(4, 3)][17:9]);
    chk(mix_err == 1'b0, "R8", "same mode no flag", mix_err, 0);
    idle_();

    // R9 lower lane early write, upper lane read in one row period
    wr_early(5, 1, 2'b11, 18'h0F0F0);
    open_row(5);
    addr = 9'd1; din = 18'h00155; we_n = 0; lcas_n = 0;
    tick();
    we_n = 1; oe_n = 0; ucas_n = 0;
    exp_q.push_back({2'b10, model[key(5, 1)]});
    tick();
    chk(mix_err == 1'b1, "R9", "mixed lanes flagged", mix_err, 1);
    chk(drv_hi == 1'b1 && drv_lo == 1'b0, "R9", "only reader drives", {drv_hi, drv_lo}, 2'b10);
    put(5, 1, 2'b01, 18'h00155);
    idle_();
    chk(mix_err == 1'b0, "R9", "flag clears", mix_err, 0);
    rd(5, 1, 2'b11, "R9");

    repeat (3) tick();
    chk(exp_q.size() == 0, "R4", "all expected reads seen", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule